// File: doc/BRIEF.md
# Step Attenuator Serial Command Writer

This block takes an attenuation request, expressed as a count of half-decibel steps, and turns it into the serial control word that a 6-bit digital step attenuator expects. The request is saturated to the top of the device range, which is 63 steps or 31.5 dB. The step count is then bit-inverted, so that zero attenuation becomes all ones. Two zero pad bits are placed in front to make a byte. The byte is shifted out most significant bit first on a serial clock and data pair. Any rounding from decibels to half-decibel steps is done by the requester, before the count reaches the block.

Several attenuators share the clock and data lines, and each one has its own latch enable. Once the eighth bit has been sent, only the addressed device sees its latch enable pulse. The two pad bits have by then overflowed out of the device's 6-bit shift register, so the device keeps only the inverted code. A busy flag covers the whole transfer, and a single-cycle done pulse closes it. A new request can be accepted in the same cycle as that done pulse.

Top module: `atten_cmd_writer`

## Requirements
- R1: A request above 63 half-dB steps (any value 64 to 127 on the 7-bit input) is saturated to 63 before encoding; values 0 to 63 pass unchanged.
- R2: The device code is the bitwise inverse of the 6-bit step count (step 0 gives code 6'b111111, step 63 gives 6'b000000), and the frame sent is {2'b00, code}.
- R3: A write strobe seen at a clock edge while busy is low is accepted: busy is high from the next cycle, and the 8 frame bits follow MSB first, each held for CLK_DIV system cycles.
- R4: Within each bit period the serial clock is low for the first CLK_DIV/2 cycles and high for the rest, so data changes only after a falling edge; while idle, clock, data and all latch enables are low.
- R5: Serial data does not change while the serial clock is high.
- R6: After the eighth bit, only the latch enable selected by the request's device index (index 0 drives bit 0) is high for CLK_DIV cycles, with the serial clock low; at most one latch enable is ever high.
- R7: In the cycle after the latch enable falls, done is high for exactly one cycle and busy is low; a strobe in that cycle starts a new transfer.
- R8: A strobe that arrives while busy is ignored: the ongoing frame, its target device and its timing are unchanged.
- R9: During and right after reset, every output is low.
- R10: A 6-bit device shift register that samples data on rising serial clock edges and latches on the rising latch enable ends up holding the inverted, saturated step count of the last request sent to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write strobe, one cycle |
| req_atten | input | REQ_W (7) | Requested attenuation in half-dB steps |
| req_sel | input | SEL_W (1) | Index of the target attenuator |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_sdo | output | 1 | Serial data, MSB first |
| spi_le | output | NUM_DEV (2) | Per-device latch enables |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions take two things for granted. Strobes arrive synchronously with the clock, and the device index is always below the number of attenuators. They do not assume that strobes are spaced apart, so a strobe during busy is legal input that the design must ignore. The stimulus drives the strobe and request fields on the falling clock edge. Every index it uses is 0 or 1. It deliberately places strobes inside a transfer and in the done cycle, to cover both the ignore path and the back-to-back path.

// File: rtl/atten_pkg.sv
package atten_pkg;
   typedef enum logic [1:0] {
      WR_IDLE  = 2'd0,
      WR_SHIFT = 2'd1,
      WR_LATCH = 2'd2,
      WR_DONE  = 2'd3
   } wr_state_e;
endpackage

// File: rtl/atten_code_map.sv
module atten_code_map #(
   parameter int REQ_W   = 7,
   parameter int CODE_W  = 6,
   parameter int FRAME_W = 8
) (
   input  logic [REQ_W-1:0]   req,
   output logic [FRAME_W-1:0] frame
);
   localparam int PAD_W    = FRAME_W - CODE_W;
   localparam int MAX_STEP = (1 << CODE_W) - 1;

   logic [CODE_W-1:0] step;

   generate
      if (REQ_W > CODE_W) begin : g_sat
         always_comb begin
            if (req > REQ_W'(MAX_STEP)) step = CODE_W'(MAX_STEP);
            else                        step = req[CODE_W-1:0];
         end
      end else begin : g_ext
         assign step = CODE_W'(req);
      end

      if (PAD_W > 0) begin : g_pad
         assign frame = {{PAD_W{1'b0}}, ~step};
      end else begin : g_nopad
         assign frame = ~step;
      end
   endgenerate
endmodule

// File: rtl/atten_le_decode.sv
module atten_le_decode #(
   parameter int NUM_DEV = 2,
   parameter int SEL_W   = 1
) (
   input  logic               en,
   input  logic [SEL_W-1:0]   sel,
   output logic [NUM_DEV-1:0] le
);
   generate
      for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
         assign le[i] = en && (sel == SEL_W'(i));
      end
   endgenerate
endmodule

// File: rtl/atten_serial_engine.sv
module atten_serial_engine
   import atten_pkg::*;
#(
   parameter int FRAME_W = 8,
   parameter int CLK_DIV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   output logic               sclk,
   output logic               sdo,
   output logic               latch,
   output logic               busy,
   output logic               done
);
   localparam int HALF  = CLK_DIV / 2;
   localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam int BIT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

   wr_state_e          state;
   logic [CNT_W-1:0]   cnt;
   logic [BIT_W-1:0]   bitn;
   logic [FRAME_W-1:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= WR_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         sh    <= '0;
      end else begin
         unique case (state)
            WR_SHIFT: begin
               if (cnt == CNT_LAST) begin
                  cnt <= '0;
                  if (bitn == BIT_LAST) begin
                     state <= WR_LATCH;
                  end else begin
                     bitn <= bitn + 1'b1;
                     sh   <= sh << 1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            WR_LATCH: begin
               if (cnt == CNT_LAST) begin
                  cnt   <= '0;
                  state <= WR_DONE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (start) begin
                  state <= WR_SHIFT;
                  sh    <= frame;
                  cnt   <= '0;
                  bitn  <= '0;
               end else begin
                  state <= WR_IDLE;
               end
            end
         endcase
      end
   end

   assign sclk  = (state == WR_SHIFT) && (cnt >= CNT_W'(HALF));
   assign sdo   = (state == WR_SHIFT) && sh[FRAME_W-1];
   assign latch = (state == WR_LATCH);
   assign busy  = (state == WR_SHIFT) || (state == WR_LATCH);
   assign done  = (state == WR_DONE);
endmodule

// File: rtl/atten_cmd_writer.sv
module atten_cmd_writer #(
   parameter int NUM_DEV = 2,
   parameter int REQ_W   = 7,
   parameter int CODE_W  = 6,
   parameter int FRAME_W = 8,
   parameter int CLK_DIV = 4,
   parameter int SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [REQ_W-1:0]   req_atten,
   input  logic [SEL_W-1:0]   req_sel,
   output logic               spi_sclk,
   output logic               spi_sdo,
   output logic [NUM_DEV-1:0] spi_le,
   output logic               busy,
   output logic               done
);
   generate
      if (CLK_DIV < 2) begin : g_bad_div
         $error("CLK_DIV must be at least 2");
      end
      if (FRAME_W < CODE_W) begin : g_bad_frame
         $error("FRAME_W must be at least CODE_W");
      end
      if (NUM_DEV < 1) begin : g_bad_dev
         $error("NUM_DEV must be at least 1");
      end
      if (REQ_W < 1 || CODE_W < 1) begin : g_bad_w
         $error("widths must be positive");
      end
   endgenerate

   logic               accept;
   logic [FRAME_W-1:0] frame;
   logic [SEL_W-1:0]   sel_q;
   logic               latch;

   assign accept = req_valid && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= '0;
      else if (accept) sel_q <= req_sel;
   end

   atten_code_map #(
      .REQ_W   (REQ_W),
      .CODE_W  (CODE_W),
      .FRAME_W (FRAME_W)
   ) u_map (
      .req   (req_atten),
      .frame (frame)
   );

   atten_serial_engine #(
      .FRAME_W (FRAME_W),
      .CLK_DIV (CLK_DIV)
   ) u_eng (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .frame (frame),
      .sclk  (spi_sclk),
      .sdo   (spi_sdo),
      .latch (latch),
      .busy  (busy),
      .done  (done)
   );

   atten_le_decode #(
      .NUM_DEV (NUM_DEV),
      .SEL_W   (SEL_W)
   ) u_dec (
      .en  (latch),
      .sel (sel_q),
      .le  (spi_le)
   );
endmodule

// File: rtl/atten_cmd_writer_chk.sv
module atten_cmd_writer_chk #(
   parameter int NUM_DEV = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               spi_sclk,
   input logic               spi_sdo,
   input logic [NUM_DEV-1:0] spi_le,
   input logic               busy,
   input logic               done
);
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy); // R3

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!spi_sclk && !spi_sdo && spi_le == '0)); // R4

   AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_sdo)); // R5

   AST_SDO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |-> $stable(spi_sdo)); // R5

   AST_LE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(spi_le)); // R6

   AST_LE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_le != '0) |-> !spi_sclk); // R6

   AST_DONE_AFTER_LE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|spi_le) |-> done); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R7

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid && !done) |=> (busy || done)); // R8
endmodule

bind atten_cmd_writer atten_cmd_writer_chk #(
   .NUM_DEV (NUM_DEV)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .spi_sclk  (spi_sclk),
   .spi_sdo   (spi_sdo),
   .spi_le    (spi_le),
   .busy      (busy),
   .done      (done)
);

// File: tb/atten_cmd_writer_tb.sv
module atten_cmd_writer_tb;
   localparam int D = 4;
   localparam int H = D / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [6:0] req_atten = '0;
   logic [0:0] req_sel = '0;
   logic       spi_sclk, spi_sdo, busy, done;
   logic [1:0] spi_le;

   always #10 clk = ~clk;

   atten_cmd_writer #(.CLK_DIV(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_atten(req_atten),
      .req_sel(req_sel), .spi_sclk(spi_sclk), .spi_sdo(spi_sdo),
      .spi_le(spi_le), .busy(busy), .done(done)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] make_frame(input int v);
      int s;
      s = (v > 63) ? 63 : v;
      return {2'b00, ~s[5:0]};
   endfunction

   // behavioural reference: position within a transfer, -1 when idle
   int         m_j = -1;
   logic [7:0] m_frame = '0;
   int         m_sel = 0;

   function automatic bit m_busy(input int j);
      return (j >= 0) && (j < 9 * D);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_j <= -1;
      end else if (!m_busy(m_j) && req_valid) begin
         m_j     <= 0;
         m_frame <= make_frame(int'(req_atten));
         m_sel   <= int'(req_sel);
      end else if (m_j >= 0) begin
         m_j <= (m_j >= 9 * D) ? -1 : m_j + 1;
      end
   end

   // compared every cycle away from the active edge
   always @(negedge clk) begin
      logic e_sclk, e_sdo, e_busy, e_done;
      logic [1:0] e_le;
      cyc++;
      e_sclk = (m_j >= 0) && (m_j < 8 * D) && ((m_j % D) >= H);
      e_sdo  = (m_j >= 0) && (m_j < 8 * D) && m_frame[7 - m_j / D];
      e_le   = ((m_j >= 8 * D) && (m_j < 9 * D)) ? 2'(1 << m_sel) : 2'b00;
      e_busy = m_busy(m_j);
      e_done = (m_j == 9 * D);
      chk(spi_sclk == e_sclk, "R4 sclk", spi_sclk, e_sclk);
      chk(spi_sdo  == e_sdo,  "R3 sdo",  spi_sdo,  e_sdo);
      chk(spi_le   == e_le,   "R6 le",   spi_le,   e_le);
      chk(busy     == e_busy, "R3 busy", busy,     e_busy);
      chk(done     == e_done, "R7 done", done,     e_done);
   end

   // attenuator model: 6-bit shift register, latch on rising enable
   logic [5:0] dev_sr = '0;
   logic [5:0] dev_q [2];
   logic [1:0] le_prev = '0;
   initial begin dev_q[0] = '0; dev_q[1] = '0; end

   always @(posedge spi_sclk) dev_sr <= {dev_sr[4:0], spi_sdo};
   always @(posedge clk) begin
      le_prev <= spi_le;
      for (int k = 0; k < 2; k++)
         if (spi_le[k] && !le_prev[k]) dev_q[k] <= dev_sr;
   end

   task automatic strobe(input int sel, input int val);
      @(negedge clk);
      req_valid = 1'b1;
      req_sel   = 1'(sel);
      req_atten = 7'(val);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done;
      while (!done) @(negedge clk);
   endtask

   task automatic write_and_check(input int sel, input int val, input string tag);
      strobe(sel, val);
      wait_done();
      chk(dev_q[sel] == make_frame(val)[5:0], tag, dev_q[sel], make_frame(val)[5:0]);
   endtask

   initial begin : watchdog
      wait (cyc > 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [5:0] keep1;
      repeat (4) @(negedge clk);
      chk({spi_sclk, spi_sdo, spi_le, busy, done} == 6'b0, "R9 in reset",
          {spi_sclk, spi_sdo, spi_le, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({spi_sclk, spi_sdo, spi_le, busy, done} == 6'b0, "R9 after reset",
          {spi_sclk, spi_sdo, spi_le, busy, done}, 0);

      write_and_check(0, 0,   "R2 R10 step0 dev0");
      write_and_check(0, 1,   "R2 R10 step1 dev0");
      write_and_check(1, 63,  "R1 R10 step63 dev1");
      write_and_check(1, 64,  "R1 R10 clamp64 dev1");
      write_and_check(0, 127, "R1 R10 clamp127 dev0");
      write_and_check(1, 42,  "R2 R10 step42 dev1");
      write_and_check(0, 21,  "R2 R10 step21 dev0");

      // R8: strobe in mid-transfer must be ignored
      keep1 = dev_q[1];
      strobe(0, 5);
      repeat (6) @(negedge clk);
      strobe(1, 50);
      wait_done();
      chk(dev_q[0] == make_frame(5)[5:0], "R8 first write kept", dev_q[0], make_frame(5)[5:0]);
      chk(dev_q[1] == keep1, "R8 other device untouched", dev_q[1], keep1);
      @(negedge clk);
      chk(busy == 1'b0, "R8 no second transfer", busy, 0);

      // R7: back-to-back, strobe in the done cycle
      strobe(1, 10);
      wait_done();
      req_valid = 1'b1; req_sel = 1'b0; req_atten = 7'd33;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R7 accepted in done cycle", busy, 1);
      chk(dev_q[1] == make_frame(10)[5:0], "R10 dev1 step10", dev_q[1], make_frame(10)[5:0]);
      wait_done();
      chk(dev_q[0] == make_frame(33)[5:0], "R7 R10 back-to-back dev0", dev_q[0], make_frame(33)[5:0]);

      repeat (5) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule